// File: doc/BRIEF.md
# Indirect Memory Access Bridge

The bridge gives a host that can only issue small decoded I/O cycles a path into a 32-bit, byte-wide core memory space. The host first loads a target address one byte at a time into four address registers, then touches a single data register. A write to the data register sends that byte to core memory at the held address. A read from the data register fetches one byte from core memory at that address and returns it.

Each host cycle starts with a one-clock request strobe. The bridge reports progress on a 4-bit sync code. Address-register accesses finish after a short wait. Data-register accesses hold a long wait while the proxied core cycle is outstanding. An external protection and lock input can veto a data-register access, and the host then sees an error code. The address is never advanced on its own, so repeated data accesses reach the same byte.

The sequencer has five states. IDLE (sync 1111) accepts a strobe. From IDLE, a strobe goes to SHORT for an address or unmapped offset, to LONG for a permitted data access, and to ERROR for a vetoed data access. SHORT always moves to READY. LONG stays put until the core acknowledges, then moves to READY. READY and ERROR each last one clock and return to IDLE.

Top module: `imb_bridge`

## Requirements
- R1: Offsets 0 to 3 select the address bytes, where offset n holds core address bits 8n+7:8n. A write there updates the matching byte of `c_addr`, and a read returns the byte held.
- R2: An access at offsets 0 to 3 or 5 to 7 gives sync 0101 (short wait) for exactly one cycle, then 0000 (ready) for one cycle, then 1111 (idle). It never raises `c_req`.
- R3: A permitted write to offset 4 raises `c_req` with `c_we`=1, `c_addr` equal to the four address bytes and `c_wdata` equal to the written byte. Sync is 0110 (long wait) for every cycle the request is pending, and 0000 follows the acknowledge cycle.
- R4: A permitted read of offset 4 raises `c_req` with `c_we`=0. The host sees sync 0000 with `h_rdata` equal to the `c_rdata` byte present at the acknowledge.
- R5: Once raised, `c_req`, `c_addr`, `c_we` and `c_wdata` stay unchanged until `c_ack` is seen. Exactly one core transfer occurs per permitted data access.
- R6: A data access while `c_permit` is 0 issues no core cycle. The next cycle shows sync 1010 (error), a read returns 0xFF, and a write is discarded.
- R7: Offsets 5 to 7 read as 0xFF, and writes to them change no address byte.
- R8: The address bytes are not modified by data-register accesses, so back-to-back data accesses use the same `c_addr`.
- R9: A strobe that arrives while an access is in progress, including in the acknowledge cycle, is ignored.
- R10: After reset, sync is 1111, `c_req` is 0 and all address bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_req | input | 1 | One-cycle host access strobe |
| h_wr | input | 1 | 1 = host write, 0 = host read |
| h_ofs | input | 3 | Register offset |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid while sync is ready or error |
| h_sync | output | 4 | Wait/ready/error code |
| c_req | output | 1 | Core memory request |
| c_we | output | 1 | Core direction, 1 = write |
| c_addr | output | 32 | Core byte address |
| c_wdata | output | 8 | Core write byte |
| c_rdata | input | 8 | Core read byte |
| c_ack | input | 1 | Core transfer complete |
| c_permit | input | 1 | Protection/lock permission for data accesses |

## Verification
Two events can fall in the same clock: the core acknowledge that ends a long wait, and a fresh host strobe that tries to start the next access. The bench raises an address-byte write exactly on the acknowledge cycle. It then checks three things: the pending read still completes with the right byte, sync drops to idle instead of starting a short wait, and the targeted address byte still holds its old value when read back.

// File: rtl/imb_pkg.sv
package imb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHORT,
        ST_LONG,
        ST_READY,
        ST_ERROR
    } imb_state_e;

    typedef enum logic [1:0] {
        ACC_ADDR,
        ACC_DATA,
        ACC_NONE
    } imb_acc_e;

    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] SYNC_SHORT = 4'b0101;
    localparam logic [3:0] SYNC_LONG  = 4'b0110;
    localparam logic [3:0] SYNC_ERROR = 4'b1010;
    localparam logic [3:0] SYNC_NONE  = 4'b1111;

endpackage

// File: rtl/imb_decode.sv
module imb_decode
    import imb_pkg::*;
#(
    parameter int OFS_W      = 3,
    parameter int ADDR_BYTES = 4
) (
    input  logic [OFS_W-1:0]      ofs,
    output imb_acc_e              kind,
    output logic [ADDR_BYTES-1:0] byte_sel
);
    localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(ADDR_BYTES);

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sel
        assign byte_sel[i] = (ofs == OFS_W'(i));
    end

    always_comb begin
        if (|byte_sel) begin
            kind = ACC_ADDR;
        end else if (ofs == DATA_OFS) begin
            kind = ACC_DATA;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/imb_addr_bank.sv
module imb_addr_bank #(
    parameter int ADDR_BYTES = 4,
    parameter int DW         = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_BYTES-1:0]      wr_sel,
    input  logic [DW-1:0]              wdata,
    input  logic [ADDR_BYTES-1:0]      rd_sel,
    output logic [ADDR_BYTES*DW-1:0]   addr,
    output logic [DW-1:0]              rd_byte
);
    logic [DW-1:0] bytes_q [ADDR_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ADDR_BYTES; i++) bytes_q[i] <= '0;
        end else begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (wr_sel[i]) bytes_q[i] <= wdata;
            end
        end
    end

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
        assign addr[i*DW +: DW] = bytes_q[i];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            rd_byte = rd_byte | (bytes_q[i] & {DW{rd_sel[i]}});
        end
    end
endmodule

// File: rtl/imb_seq.sv
module imb_seq
    import imb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  imb_acc_e   kind,
    input  logic       permit,
    input  logic       core_ack,
    output logic       accept,
    output logic       core_fin,
    output logic       core_req,
    output logic [3:0] sync
);
    imb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (kind != ACC_DATA) state_d = ST_SHORT;
                    else if (permit)      state_d = ST_LONG;
                    else                  state_d = ST_ERROR;
                end
            end
            ST_SHORT: state_d = ST_READY;
            ST_LONG:  if (core_ack) state_d = ST_READY;
            ST_READY: state_d = ST_IDLE;
            ST_ERROR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        core_fin = 1'b0;
        core_req = 1'b0;
        sync     = SYNC_NONE;
        unique case (state_q)
            ST_IDLE:  accept = start;
            ST_SHORT: sync = SYNC_SHORT;
            ST_LONG: begin
                sync     = SYNC_LONG;
                core_req = 1'b1;
                core_fin = core_ack;
            end
            ST_READY: sync = SYNC_READY;
            ST_ERROR: sync = SYNC_ERROR;
            default:  sync = SYNC_NONE;
        endcase
    end
endmodule

// File: rtl/imb_bridge.sv
module imb_bridge
    import imb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DW         = 8,
    parameter int OFS_W      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       h_req,
    input  logic                       h_wr,
    input  logic [OFS_W-1:0]           h_ofs,
    input  logic [DW-1:0]              h_wdata,
    output logic [DW-1:0]              h_rdata,
    output logic [3:0]                 h_sync,
    output logic                       c_req,
    output logic                       c_we,
    output logic [ADDR_BYTES*DW-1:0]   c_addr,
    output logic [DW-1:0]              c_wdata,
    input  logic [DW-1:0]              c_rdata,
    input  logic                       c_ack,
    input  logic                       c_permit
);
    localparam int AW = ADDR_BYTES * DW;

    imb_acc_e              kind;
    logic [ADDR_BYTES-1:0] byte_sel;
    logic [ADDR_BYTES-1:0] addr_wr;
    logic [DW-1:0]         bank_rd;
    logic [AW-1:0]         bank_addr;
    logic                  accept;
    logic                  core_fin;
    logic [DW-1:0]         data_q;
    logic [DW-1:0]         rd_q;
    logic                  we_q;

    imb_decode #(.OFS_W(OFS_W), .ADDR_BYTES(ADDR_BYTES)) u_dec (
        .ofs      (h_ofs),
        .kind     (kind),
        .byte_sel (byte_sel)
    );

    assign addr_wr = byte_sel & {ADDR_BYTES{accept && h_wr}};

    imb_addr_bank #(.ADDR_BYTES(ADDR_BYTES), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (addr_wr),
        .wdata   (h_wdata),
        .rd_sel  (byte_sel),
        .addr    (bank_addr),
        .rd_byte (bank_rd)
    );

    imb_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (h_req),
        .kind     (kind),
        .permit   (c_permit),
        .core_ack (c_ack),
        .accept   (accept),
        .core_fin (core_fin),
        .core_req (c_req),
        .sync     (h_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rd_q   <= '0;
            we_q   <= 1'b0;
        end else begin
            if (accept) begin
                we_q <= h_wr;
                rd_q <= (kind == ACC_ADDR) ? bank_rd : '1;
                if (h_wr && kind == ACC_DATA && c_permit) data_q <= h_wdata;
            end
            if (core_fin && !we_q) begin
                data_q <= c_rdata;
                rd_q   <= c_rdata;
            end
        end
    end

    assign h_rdata = rd_q;
    assign c_we    = we_q;
    assign c_addr  = bank_addr;
    assign c_wdata = data_q;
endmodule

// File: rtl/imb_bridge_chk.sv
module imb_bridge_chk
    import imb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DW         = 8,
    parameter int OFS_W      = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     h_req,
    input logic                     h_wr,
    input logic [OFS_W-1:0]         h_ofs,
    input logic [DW-1:0]            h_wdata,
    input logic [3:0]               h_sync,
    input logic                     c_req,
    input logic                     c_we,
    input logic [ADDR_BYTES*DW-1:0] c_addr,
    input logic [DW-1:0]            c_wdata,
    input logic                     c_ack,
    input logic                     c_permit
);
    localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(ADDR_BYTES);

    assert_addr_byte0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_wr && h_ofs == '0 && h_sync == SYNC_NONE)
        |=> c_addr[DW-1:0] == $past(h_wdata));

    assert_short_then_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sync == SYNC_SHORT) |=> (h_sync == SYNC_READY));

    assert_short_no_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sync == SYNC_SHORT) |-> !c_req);

    assert_req_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_req |-> (h_sync == SYNC_LONG));

    assert_ack_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack) |=> (h_sync == SYNC_READY && !c_req));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ack) |=> (c_req && $stable(c_addr) && $stable(c_we) && $stable(c_wdata)));

    assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_ofs == DATA_OFS && !c_permit && h_sync == SYNC_NONE)
        |=> (!c_req && h_sync == SYNC_ERROR));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sync == SYNC_READY) |=> (h_sync == SYNC_NONE));
endmodule

bind imb_bridge imb_bridge_chk #(
    .ADDR_BYTES (ADDR_BYTES),
    .DW         (DW),
    .OFS_W      (OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_req    (h_req),
    .h_wr     (h_wr),
    .h_ofs    (h_ofs),
    .h_wdata  (h_wdata),
    .h_sync   (h_sync),
    .c_req    (c_req),
    .c_we     (c_we),
    .c_addr   (c_addr),
    .c_wdata  (c_wdata),
    .c_ack    (c_ack),
    .c_permit (c_permit)
);

// File: tb/tb_imb_bridge.sv
`timescale 1ns/1ps
module tb_imb_bridge;
    localparam logic [3:0] S_READY = 4'b0000;
    localparam logic [3:0] S_SHORT = 4'b0101;
    localparam logic [3:0] S_LONG  = 4'b0110;
    localparam logic [3:0] S_ERROR = 4'b1010;
    localparam logic [3:0] S_NONE  = 4'b1111;

    typedef struct packed {
        logic       wr;
        logic [2:0] ofs;
        logic [7:0] wd;
        logic       perm;
        logic [3:0] lat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'h78, 1'b1, 4'd1},
        '{1'b1, 3'd1, 8'h56, 1'b1, 4'd1},
        '{1'b1, 3'd2, 8'h34, 1'b1, 4'd1},
        '{1'b1, 3'd3, 8'h12, 1'b1, 4'd1},
        '{1'b0, 3'd2, 8'h00, 1'b1, 4'd1},
        '{1'b1, 3'd4, 8'hC3, 1'b1, 4'd2},
        '{1'b0, 3'd4, 8'h00, 1'b1, 4'd1},
        '{1'b0, 3'd4, 8'h00, 1'b1, 4'd4},
        '{1'b0, 3'd4, 8'h00, 1'b0, 4'd1},
        '{1'b1, 3'd4, 8'hAA, 1'b0, 4'd1},
        '{1'b1, 3'd6, 8'h99, 1'b1, 4'd1},
        '{1'b0, 3'd5, 8'h00, 1'b1, 4'd1},
        '{1'b0, 3'd0, 8'h00, 1'b1, 4'd1},
        '{1'b1, 3'd3, 8'h80, 1'b1, 4'd1},
        '{1'b1, 3'd4, 8'h5E, 1'b1, 4'd3},
        '{1'b0, 3'd3, 8'h00, 1'b1, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [2:0]  h_ofs = '0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic [3:0]  h_sync;
    logic        c_req, c_we;
    logic [31:0] c_addr;
    logic [7:0]  c_wdata;
    logic [7:0]  c_rdata = '0;
    logic        c_ack = 1'b0;
    logic        c_permit = 1'b1;

    int tests = 0, fails = 0;
    int lat = 1, cnt = 0, xfers = 0;
    logic [31:0] log_addr;
    logic        log_we;
    logic [7:0]  log_wdata;
    logic [7:0]  sa [4];

    always #5 clk = ~clk;

    imb_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_ofs(h_ofs),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_sync(h_sync), .c_req(c_req),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .c_ack(c_ack), .c_permit(c_permit)
    );

    function automatic logic [7:0] mem_model(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
    endfunction

    // core memory model: acknowledges after lat cycles of pending request
    always @(negedge clk) begin
        if (c_req && !c_ack) begin
            cnt = cnt + 1;
            if (cnt >= lat) begin
                c_ack   = 1'b1;
                c_rdata = mem_model(c_addr);
            end
        end else begin
            c_ack = 1'b0;
            cnt   = 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && c_req && c_ack) begin
            xfers     <= xfers + 1;
            log_addr  <= c_addr;
            log_we    <= c_we;
            log_wdata <= c_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] shadow_addr();
        return {sa[3], sa[2], sa[1], sa[0]};
    endfunction

    task automatic run_vec(input vec_t v, input string req);
        int nw;
        int x0;
        logic [3:0] code, wcode, ecode;
        logic [7:0] erd;
        int ewait;
        int exf;
        logic [31:0] ea;
        ea = shadow_addr();
        x0 = xfers;
        exf = 0;
        erd = 8'hFF;
        if (v.ofs < 3'd4) begin
            wcode = S_SHORT; ewait = 1; ecode = S_READY; erd = sa[v.ofs[1:0]];
        end else if (v.ofs == 3'd4 && v.perm) begin
            wcode = S_LONG; ewait = int'(v.lat); ecode = S_READY; exf = 1;
            erd = mem_model(ea);
        end else if (v.ofs == 3'd4) begin
            wcode = S_LONG; ewait = 0; ecode = S_ERROR;
        end else begin
            wcode = S_SHORT; ewait = 1; ecode = S_READY;
        end
        @(negedge clk);
        h_req = 1'b1; h_wr = v.wr; h_ofs = v.ofs; h_wdata = v.wd;
        c_permit = v.perm; lat = int'(v.lat);
        @(negedge clk);
        h_req = 1'b0;
        nw = 0;
        code = h_sync;
        while ((code == S_SHORT || code == S_LONG) && nw < 40) begin
            check(code == wcode, req, "wait code", {28'd0, code}, {28'd0, wcode});
            nw++;
            @(negedge clk);
            code = h_sync;
        end
        check(nw == ewait, req, "wait cycles", nw, ewait);
        check(code == ecode, req, "final sync", {28'd0, code}, {28'd0, ecode});
        if (!v.wr)
            check(h_rdata == erd, req, "read data", {24'd0, h_rdata}, {24'd0, erd});
        @(negedge clk);
        check(h_sync == S_NONE, req, "idle after", {28'd0, h_sync}, {28'd0, S_NONE});
        check(xfers - x0 == exf, req, "core transfers", xfers - x0, exf);
        if (exf == 1) begin
            check(log_addr == ea, req, "core addr", log_addr, ea);
            check(log_we == v.wr, req, "core dir", {31'd0, log_we}, {31'd0, v.wr});
            if (v.wr)
                check(log_wdata == v.wd, req, "core wdata", {24'd0, log_wdata}, {24'd0, v.wd});
        end
        if (v.wr && v.ofs < 3'd4) sa[v.ofs[1:0]] = v.wd;
        check(c_addr == shadow_addr(), req, "c_addr", c_addr, shadow_addr());
    endtask

    function automatic string req_of(input vec_t v);
        if (v.ofs < 3'd4)  return "R1/R2";
        if (v.ofs > 3'd4)  return "R7";
        if (!v.perm)       return "R6";
        if (v.wr)          return "R3";
        return "R4/R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) sa[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(h_sync == S_NONE, "R10", "sync in reset", {28'd0, h_sync}, {28'd0, S_NONE});
        check(c_req == 1'b0, "R10", "c_req in reset", {31'd0, c_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(c_addr == 32'd0, "R10", "address after reset", c_addr, 32'd0);
        check(h_sync == S_NONE, "R10", "idle after reset", {28'd0, h_sync}, {28'd0, S_NONE});

        for (int i = 0; i < NV; i++) run_vec(VECS[i], req_of(VECS[i]));

        // R5: long hold, request stable over several cycles
        run_vec('{1'b1, 3'd4, 8'h3C, 1'b1, 4'd6}, "R5");

        // R9: strobe in the middle of a long wait is ignored
        begin
            int x0;
            x0 = xfers;
            @(negedge clk);
            h_req = 1'b1; h_wr = 1'b1; h_ofs = 3'd4; h_wdata = 8'h11; c_permit = 1'b1; lat = 5;
            @(negedge clk);
            h_req = 1'b0;
            @(negedge clk);
            h_req = 1'b1; h_wr = 1'b1; h_ofs = 3'd1; h_wdata = 8'h00;
            @(negedge clk);
            h_req = 1'b0;
            for (int k = 0; k < 20 && h_sync != S_READY; k++) @(negedge clk);
            check(h_sync == S_READY, "R9", "mid-wait completion", {28'd0, h_sync}, {28'd0, S_READY});
            @(negedge clk);
            check(h_sync == S_NONE, "R9", "idle after mid-wait", {28'd0, h_sync}, {28'd0, S_NONE});
            check(xfers - x0 == 1, "R9", "single transfer", xfers - x0, 1);
            check(log_wdata == 8'h11, "R9", "write byte kept", {24'd0, log_wdata}, 32'h11);
        end
        run_vec('{1'b0, 3'd1, 8'h00, 1'b1, 4'd1}, "R9");

        // R9: strobe in the same cycle as the core acknowledge
        begin
            int x0;
            logic [7:0] erd;
            x0 = xfers;
            erd = mem_model(shadow_addr());
            @(negedge clk);
            h_req = 1'b1; h_wr = 1'b0; h_ofs = 3'd4; c_permit = 1'b1; lat = 3;
            @(negedge clk);
            h_req = 1'b0;
            @(negedge clk);
            @(negedge clk);
            h_req = 1'b1; h_wr = 1'b1; h_ofs = 3'd0; h_wdata = 8'hEE;
            @(negedge clk);
            h_req = 1'b0;
            check(h_sync == S_READY, "R9", "ready at ack overlap", {28'd0, h_sync}, {28'd0, S_READY});
            check(h_rdata == erd, "R9", "read data at overlap", {24'd0, h_rdata}, {24'd0, erd});
            @(negedge clk);
            check(h_sync == S_NONE, "R9", "no new access started", {28'd0, h_sync}, {28'd0, S_NONE});
            check(xfers - x0 == 1, "R9", "single transfer", xfers - x0, 1);
        end
        run_vec('{1'b0, 3'd0, 8'h00, 1'b1, 4'd1}, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule